// File: doc/BRIEF.md
# Guarded Word Store Unit

This block sits between the issue stage of a core and a 32-bit data memory port with byte lanes. Each cycle it may accept one word store request. The request carries a predicate bit, a byte address, a data word, the byte-order mode currently selected, a flag marking the address as memory-mapped I/O, and a trap-enable bit for misaligned stores. An accepted store is placed on a registered write port one cycle later. That port carries a word address, four byte enables and the data already rotated into its byte lanes.

Byte order is selected at run time. Byte k of the word, with k=0 the most significant byte, is written to byte offset k XOR s within the word. s is 3 in little-endian mode and 0 in big-endian mode. I/O accesses always use s=0.

A store whose predicate bit is zero does nothing at all. A store to an address that is not word aligned is not written. It sets a sticky status flag instead. If the trap is enabled, it also leaves an exception request pending, and that request is handed over on the next interruptible jump.

Top module: `word_store_unit`

## Requirements
- R1: After reset, `wr_en` is 0, `wr_be` is 0, `misalign_flag` is 0 and `exc_pending` is 0.
- R2: For a request with `req_valid`=1, `req_guard`=1 and `req_addr[1:0]`=0, the next cycle shows `wr_en`=1, `wr_be`=4'b1111 and `wr_word_addr`=`req_addr[31:2]`.
- R3: Write lane j is `wr_data[8j+7:8j]` and corresponds to byte offset j. With `mode_little`=0 and `req_io`=0, lane j holds byte j of the word, where byte 0 is `req_data[31:24]`. For example, 0x44332211 appears as `wr_data`=0x11223344.
- R4: With `mode_little`=1 and `req_io`=0, lane j holds byte 3-j of the word, so `wr_data` equals `req_data`.
- R5: With `req_io`=1, the lane placement of R3 applies whatever the value of `mode_little`.
- R6: A request with `req_guard`=0 produces no write and leaves `misalign_flag` and `exc_pending` unchanged. This holds whatever the address, trap-enable bit and data are.
- R7: A guarded request with `req_addr[1:0]`≠0 produces no write (`wr_en`=0, `wr_be`=0). It sets `misalign_flag` to 1 in the next cycle.
- R8: `misalign_flag` stays at 1 until a cycle with `status_clr`=1. If a new misaligned store arrives in that same cycle, the flag stays at 1.
- R9: A guarded misaligned request with `trap_en`=1 sets `exc_pending` in the next cycle. With `trap_en`=0, `exc_pending` is not set.
- R10: `exc_take` equals `exc_pending` AND `jump_strobe` within the same cycle. After a cycle with `jump_strobe`=1, `exc_pending` is 0, unless a trapping misaligned store arrived in that same cycle.
- R11: A cycle with `req_valid`=0 produces no write in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Store request strobe |
| req_guard | input | 1 | Least significant bit of the guard register |
| req_addr | input | 32 | Byte address of the store |
| req_data | input | 32 | Word to store |
| mode_little | input | 1 | 1 = little-endian, 0 = big-endian |
| req_io | input | 1 | Address lies in the memory-mapped I/O aperture |
| trap_en | input | 1 | Request an exception on a misaligned store |
| jump_strobe | input | 1 | Core is executing an interruptible jump |
| status_clr | input | 1 | Synchronous clear of the misaligned flag |
| wr_en | output | 1 | Registered write strobe |
| wr_word_addr | output | 30 | Registered word address |
| wr_be | output | 4 | Registered byte enables |
| wr_data | output | 32 | Registered lane-placed data |
| misalign_flag | output | 1 | Sticky misaligned-store status |
| exc_pending | output | 1 | Exception request awaiting a jump |
| exc_take | output | 1 | Exception handed over this cycle |

## Verification
The hardest situations to reach are the collisions between status events. One is a misaligned store that lands in the same cycle as a flag clear. Another is a trapping misaligned store that lands in the same cycle as the jump that is delivering an earlier request. The stimulus builds each of these on purpose: it first leaves a request pending, then issues the colliding store together with the clear or the jump. It then checks that the new event survives. Around this, a full sweep covers every address offset, byte order, I/O flag, guard value and trap-enable value. Each sweep step starts from cleared status, so every effect on the flag is seen in isolation.

// File: rtl/wsu_pkg.sv
package wsu_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic {
    ORDER_BIG    = 1'b0,
    ORDER_LITTLE = 1'b1
  } byte_order_e;
endpackage

// File: rtl/wsu_lane_mapper.sv
module wsu_lane_mapper #(
  parameter int LANES = 4
) (
  input  logic [LANES*wsu_pkg::BYTE_W-1:0] word_in,
  input  logic                             swap_en,
  output logic [LANES*wsu_pkg::BYTE_W-1:0] lanes_out
);
  localparam int BW = wsu_pkg::BYTE_W;
  localparam int WW = LANES * BW;

  // Lane j (byte offset j) takes word byte k = j XOR s, with byte 0 the
  // most significant; s is LANES-1 when swapping, 0 otherwise.
  function automatic logic [WW-1:0] place_bytes(input logic [WW-1:0] w,
                                                input logic sw);
    logic [WW-1:0] r;
    int k;
    r = '0;
    for (int j = 0; j < LANES; j++) begin
      k = sw ? (j ^ (LANES - 1)) : j;
      r[BW*j +: BW] = w[BW*(LANES-1-k) +: BW];
    end
    return r;
  endfunction

  assign lanes_out = place_bytes(word_in, swap_en);
endmodule

// File: rtl/wsu_write_stage.sv
module wsu_write_stage #(
  parameter int LANES  = 4,
  parameter int WADR_W = 30
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             do_write,
  input  logic [WADR_W-1:0]                word_addr,
  input  logic [LANES*wsu_pkg::BYTE_W-1:0] lanes,
  output logic                             wr_en,
  output logic [WADR_W-1:0]                wr_word_addr,
  output logic [LANES-1:0]                 wr_be,
  output logic [LANES*wsu_pkg::BYTE_W-1:0] wr_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en        <= 1'b0;
      wr_word_addr <= '0;
      wr_be        <= '0;
      wr_data      <= '0;
    end else begin
      wr_en <= do_write;
      wr_be <= do_write ? {LANES{1'b1}} : '0;
      if (do_write) begin
        wr_word_addr <= word_addr;
        wr_data      <= lanes;
      end
    end
  end
endmodule

// File: rtl/wsu_status.sv
module wsu_status (
  input  logic clk,
  input  logic rst_n,
  input  logic mis_event,
  input  logic trap_en,
  input  logic jump_strobe,
  input  logic status_clr,
  output logic misalign_flag,
  output logic exc_pending,
  output logic exc_take
);
  logic trap_event;
  assign trap_event = mis_event & trap_en;
  assign exc_take   = exc_pending & jump_strobe;

  // A new event wins over a clear or a delivery in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      misalign_flag <= 1'b0;
      exc_pending   <= 1'b0;
    end else begin
      if (mis_event)       misalign_flag <= 1'b1;
      else if (status_clr) misalign_flag <= 1'b0;
      if (trap_event)       exc_pending <= 1'b1;
      else if (jump_strobe) exc_pending <= 1'b0;
    end
  end

  assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mis_event |=> misalign_flag);
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_flag && !status_clr |=> misalign_flag);
  assert_trap_pend_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_event |=> exc_pending);
  assert_no_spurious_pend_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_pending && !trap_event |=> !exc_pending);
  assert_jump_delivers_R10: assert property (@(posedge clk) disable iff (!rst_n)
    exc_pending && jump_strobe && !trap_event |=> !exc_pending);
endmodule

// File: rtl/word_store_unit.sv
module word_store_unit #(
  parameter int ADDR_W = 32,
  parameter int LANES  = 4,
  localparam int DATA_W = LANES * wsu_pkg::BYTE_W,
  localparam int OFF_W  = $clog2(LANES),
  localparam int WADR_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_guard,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              mode_little,
  input  logic              req_io,
  input  logic              trap_en,
  input  logic              jump_strobe,
  input  logic              status_clr,
  output logic              wr_en,
  output logic [WADR_W-1:0] wr_word_addr,
  output logic [LANES-1:0]  wr_be,
  output logic [DATA_W-1:0] wr_data,
  output logic              misalign_flag,
  output logic              exc_pending,
  output logic              exc_take
);
  import wsu_pkg::*;

  function automatic logic is_unaligned(input logic [ADDR_W-1:0] a);
    return |a[OFF_W-1:0];
  endfunction

  logic        store_fire;
  logic        unaligned;
  logic        aligned_store;
  logic        mis_event;
  logic        swap_en;
  byte_order_e order;
  logic [DATA_W-1:0] lanes;

  assign order         = byte_order_e'(mode_little);
  assign store_fire    = req_valid & req_guard;
  assign unaligned     = is_unaligned(req_addr);
  assign aligned_store = store_fire & ~unaligned;
  assign mis_event     = store_fire & unaligned;
  assign swap_en       = (order == ORDER_LITTLE) & ~req_io;

  wsu_lane_mapper #(.LANES(LANES)) u_map (
    .word_in  (req_data),
    .swap_en  (swap_en),
    .lanes_out(lanes)
  );

  wsu_write_stage #(.LANES(LANES), .WADR_W(WADR_W)) u_wr (
    .clk         (clk),
    .rst_n       (rst_n),
    .do_write    (aligned_store),
    .word_addr   (req_addr[ADDR_W-1:OFF_W]),
    .lanes       (lanes),
    .wr_en       (wr_en),
    .wr_word_addr(wr_word_addr),
    .wr_be       (wr_be),
    .wr_data     (wr_data)
  );

  wsu_status u_st (
    .clk          (clk),
    .rst_n        (rst_n),
    .mis_event    (mis_event),
    .trap_en      (trap_en),
    .jump_strobe  (jump_strobe),
    .status_clr   (status_clr),
    .misalign_flag(misalign_flag),
    .exc_pending  (exc_pending),
    .exc_take     (exc_take)
  );

  assert_aligned_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_guard && !unaligned |=>
      wr_en && wr_be == {LANES{1'b1}} &&
      wr_word_addr == $past(req_addr[ADDR_W-1:OFF_W]));
  assert_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !wr_en && wr_be == '0);
  assert_guard_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_guard && !status_clr && !jump_strobe |=>
      !wr_en && $stable(misalign_flag) && $stable(exc_pending));
  assert_unaligned_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && unaligned |=> !wr_en && wr_be == '0);
endmodule

// File: tb/word_store_unit_test.sv
`timescale 1ns/1ps
module word_store_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_guard = 0, mode_little = 0, req_io = 0;
  logic trap_en = 0, jump_strobe = 0, status_clr = 0;
  logic [31:0] req_addr = '0, req_data = '0;
  logic wr_en, misalign_flag, exc_pending, exc_take;
  logic [29:0] wr_word_addr;
  logic [3:0] wr_be;
  logic [31:0] wr_data;

  int checks = 0;
  int errors = 0;
  logic exp_flag = 0, exp_pend = 0;

  always #2.5 clk = ~clk;

  word_store_unit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_guard(req_guard),
    .req_addr(req_addr), .req_data(req_data), .mode_little(mode_little),
    .req_io(req_io), .trap_en(trap_en), .jump_strobe(jump_strobe),
    .status_clr(status_clr), .wr_en(wr_en), .wr_word_addr(wr_word_addr),
    .wr_be(wr_be), .wr_data(wr_data), .misalign_flag(misalign_flag),
    .exc_pending(exc_pending), .exc_take(exc_take)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Byte at offset j: little-endian non-I/O takes byte (3-j) from the top.
  function automatic logic [31:0] expect_lanes(logic [31:0] d, logic lit, logic io);
    logic [31:0] r = '0;
    for (int j = 0; j < 4; j++) begin
      int k = (lit && !io) ? 3 - j : j;
      r = r | (((d >> (24 - 8 * k)) & 32'hFF) << (8 * j));
    end
    return r;
  endfunction

  // Called at a falling edge; drives one cycle and checks the registered result.
  task automatic step(input logic v, input logic g, input logic [31:0] a,
                      input logic [31:0] d, input logic lit, input logic io,
                      input logic tr, input logic jmp, input logic clr, input string tag);
    logic fire, mis, exp_we;
    req_valid = v; req_guard = g; req_addr = a; req_data = d;
    mode_little = lit; req_io = io; trap_en = tr; jump_strobe = jmp; status_clr = clr;
    fire = v & g;
    mis = (a[1:0] != 2'b00);
    exp_we = fire & !mis;
    #1;
    check({tag, " R10 take"}, {31'b0, exc_take}, {31'b0, exp_pend & jmp});
    exp_flag = (fire & mis) ? 1'b1 : (clr ? 1'b0 : exp_flag);
    exp_pend = (fire & mis & tr) ? 1'b1 : (jmp ? 1'b0 : exp_pend);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; jump_strobe = 0; status_clr = 0;
    check({tag, " R2/R6/R7/R11 wr_en"}, {31'b0, wr_en}, {31'b0, exp_we});
    if (exp_we) begin
      check({tag, " R2 be"}, {28'b0, wr_be}, 32'hF);
      check({tag, " R2 addr"}, {2'b0, wr_word_addr}, {2'b0, a[31:2]});
      check({tag, io ? " R5 data" : (lit ? " R4 data" : " R3 data")},
            wr_data, expect_lanes(d, lit, io));
    end else begin
      check({tag, " R7 be"}, {28'b0, wr_be}, 32'h0);
    end
    check({tag, " R7/R8 flag"}, {31'b0, misalign_flag}, {31'b0, exp_flag});
    check({tag, " R9/R10 pend"}, {31'b0, exc_pending}, {31'b0, exp_pend});
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 wr_en", {31'b0, wr_en}, 0);
    check("R1 be", {28'b0, wr_be}, 0);
    check("R1 flag", {31'b0, misalign_flag}, 0);
    check("R1 pend", {31'b0, exc_pending}, 0);
    rst_n = 1;
    @(negedge clk);

    step(1, 1, 32'h0000_0d00, 32'h4433_2211, 0, 0, 0, 0, 0, "R3 example");
    check("R3 literal", wr_data, 32'h1122_3344);
    step(0, 1, 32'h0000_0d04, 32'hAABB_CCDD, 1, 0, 1, 0, 0, "R11 idle");

    for (int off = 0; off < 4; off++)
      for (int lit = 0; lit < 2; lit++)
        for (int io = 0; io < 2; io++)
          for (int g = 0; g < 2; g++)
            for (int tr = 0; tr < 2; tr++) begin
              step(0, 0, 0, 0, 0, 0, 0, 1, 1, "clear");
              step(1, g[0], 32'h1000_0000 + 32'(off) + 32'(lit * 64 + io * 32 + tr * 16),
                   32'h0102_0304 * 32'(off + 1) ^ {8'(lit), 8'(io), 8'(g), 8'(tr)},
                   lit[0], io[0], tr[0], 0, 0, g[0] ? "sweep" : "R6 sweep");
            end

    step(1, 1, 32'h0000_0d01, 32'hAABB_CCDD, 0, 0, 1, 0, 0, "R9 set");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R8 hold");
    step(1, 0, 32'h0000_0d02, 32'h1, 0, 0, 1, 0, 0, "R6 unaligned guard off");
    step(1, 1, 32'h0000_0d03, 32'h2, 0, 0, 0, 0, 1, "R8 set beats clr");
    step(1, 1, 32'h0000_0d05, 32'h3, 1, 0, 1, 1, 0, "R10 set beats jump");
    step(0, 0, 0, 0, 0, 0, 0, 1, 1, "R10 deliver");
    step(0, 0, 0, 0, 0, 0, 0, 1, 0, "R10 idle jump");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule